// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

This block is a memory-mapped event timer. A single 32-bit free-running counter advances by one on every clock while a global run bit is set. Several comparator channels watch that counter. When a channel matches, it raises an interrupt. Each channel can work in one of two ways. In single-shot mode it fires once and then waits to be re-armed. In repeating mode it fires and then moves its own compare point forward by a stored interval.

Software drives the block through a small register bus with a 1024-byte window. Reads return data combinationally in the same cycle. Writes take effect at the next clock edge. Each channel can signal in one of two ways. In pulse mode it gives a one-cycle strobe on every match. In level mode it sets a sticky status bit that software clears by writing a one. Repeating mode uses a two-step write sequence on the comparator address. While the channel's arm-value bit is set, a write places the first expiry time. Every later write in repeating mode sets the interval.

Top module: `evt_timer`

## Requirements
- R1: Offset 0x000 reads a fixed capability word. Bits [7:0] hold the revision (1). Bits [12:8] hold the channel count minus one. Bit 13 is the wide-counter flag and reads 0. Offset 0x004 reads the tick period in femtoseconds.
- R2: The counter (offset 0x0F0) resets to 0 and holds its value while bit 0 of the general register (offset 0x010) is 0. It increments by one per clock while that bit is 1. A bus write loads the counter.
- R3: A channel in single-shot mode produces exactly one interrupt when the counter equals its comparator. It produces no further interrupt until software writes the comparator again.
- R4: In repeating mode, a comparator write made while the arm-value bit (config bit 6) is 1 loads the first expiry and clears that bit. A write made while the bit is 0 loads the interval. After each match the comparator advances by the interval.
- R5: The repeat-capable bit (config bit 4) is read-only. The single-width bit (config bit 5) is read-only and reads 1. On a channel that is not repeat-capable, a write of 1 to the repeating-mode bit (config bit 3) is ignored.
- R6: In level mode (config bit 1 = 1), a match sets status bit n for channel n at offset 0x020. A write of 1 to that bit clears it. A write of 0 leaves it unchanged. While the channel's enable is on, its interrupt output follows the status bit.
- R7: While a channel's interrupt enable (config bit 2) is 0, its interrupt output stays low. A level-mode channel still records status on a match in this state.
- R8: In pulse mode, a match gives a high interrupt output for exactly one cycle, in the cycle after the matching count. It sets no status bit.
- R9: The counter wraps from 0xFFFFFFFF to 0.
- R10: Channel n has its config register at 0x100 + 0x20·n and its comparator at 0x108 + 0x20·n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access valid |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Byte address within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle |
| irqOut | output | NCH | One interrupt line per channel |

## Verification
The compare function is exercised with several input patterns, one per behaviour to be told apart. The single-shot case uses a far compare point and is then left running, which separates one fire from repeated fires. The repeating case uses a distinct first expiry and interval, so an interval that loads into the wrong register shows up as shifted pulse times. A scoreboard predicts the exact cycle of every pulse on channel 0, so an off-by-one in the counter, the match or the output register is caught as a timing error. Level-mode runs with the enable on and off, followed by clears with a zero and a one, separate the status path from the output gating.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 5;

  // channel config bit positions
  localparam int CFG_LEVEL    = 1;
  localparam int CFG_INTEN    = 2;
  localparam int CFG_PERIODIC = 3;
  localparam int CFG_PCAP     = 4;
  localparam int CFG_FORCE32  = 5;
  localparam int CFG_VALSET   = 6;

  typedef enum logic [2:0] {
    RD_NONE, RD_CAPS, RD_PERIOD, RD_GEN, RD_STAT, RD_CNT, RD_CFG, RD_CMP
  } rdSel_e;

  typedef struct packed {
    logic             genWr;
    logic             statWr;
    logic             cntWr;
    logic             cfgWr;
    logic             cmpWr;
    logic [IDX_W-1:0] chanIdx;
    rdSel_e           rdSel;
  } busStrobe_t;
endpackage

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);
  localparam logic [IDX_W-1:0] SLOT_BASE = IDX_W'(8);

  logic [IDX_W-1:0] slot;
  logic [IDX_W-1:0] idx;
  logic             inChan;
  logic             wr;

  always_comb begin
    strobe  = '0;
    slot    = busAddr[ADDR_W-1:5];
    idx     = slot - SLOT_BASE;
    inChan  = (slot >= SLOT_BASE) && (idx < IDX_W'(NCH));
    wr      = busSel && busWr;
    strobe.chanIdx = idx;
    strobe.rdSel   = RD_NONE;
    if (busSel) begin
      if (busAddr == 10'h000) begin
        strobe.rdSel = RD_CAPS;
      end else if (busAddr == 10'h004) begin
        strobe.rdSel = RD_PERIOD;
      end else if (busAddr == 10'h010) begin
        strobe.rdSel = RD_GEN;
        strobe.genWr = wr;
      end else if (busAddr == 10'h020) begin
        strobe.rdSel  = RD_STAT;
        strobe.statWr = wr;
      end else if (busAddr == 10'h0F0) begin
        strobe.rdSel = RD_CNT;
        strobe.cntWr = wr;
      end else if (inChan && busAddr[4:0] == 5'h00) begin
        strobe.rdSel = RD_CFG;
        strobe.cfgWr = wr;
      end else if (inChan && busAddr[4:0] == 5'h08) begin
        strobe.rdSel = RD_CMP;
        strobe.cmpWr = wr;
      end
    end
  end
endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
  import evt_timer_pkg::*;
#(
  parameter bit PCAP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cfgWr,
  input  logic              cmpWr,
  input  logic              statusBit,
  output logic [DATA_W-1:0] cfgWord,
  output logic [DATA_W-1:0] cmpVal,
  output logic              setStatus,
  output logic              irq
);
  logic              levelQ, intEnQ, perQ, valSetQ, armedQ, edgeQ;
  logic [DATA_W-1:0] cmpQ, periodQ;
  logic              fire, loadCmp;

  assign fire      = run && armedQ && (count == cmpQ);
  assign setStatus = fire && levelQ;
  // in repeating mode without the arm-value bit a write targets the interval
  assign loadCmp   = cmpWr && !(perQ && !valSetQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ  <= 1'b0;
      intEnQ  <= 1'b0;
      perQ    <= 1'b0;
      valSetQ <= 1'b0;
      armedQ  <= 1'b0;
      edgeQ   <= 1'b0;
      cmpQ    <= '1;
      periodQ <= '0;
    end else begin
      if (cfgWr) begin
        levelQ  <= wdata[CFG_LEVEL];
        intEnQ  <= wdata[CFG_INTEN];
        perQ    <= wdata[CFG_PERIODIC] & PCAP;
        valSetQ <= wdata[CFG_VALSET];
      end
      if (cmpWr && !loadCmp) periodQ <= wdata;
      if (loadCmp) begin
        cmpQ   <= wdata;
        armedQ <= 1'b1;
        if (perQ) valSetQ <= 1'b0;
      end else if (fire) begin
        if (perQ) cmpQ <= cmpQ + periodQ;
        else      armedQ <= 1'b0;
      end
      edgeQ <= fire && !levelQ;
    end
  end

  assign cfgWord = {{(DATA_W-7){1'b0}}, valSetQ, 1'b1, PCAP, perQ, intEnQ, levelQ, 1'b0};
  assign cmpVal  = cmpQ;
  assign irq     = intEnQ && (levelQ ? statusBit : edgeQ);

  assert_oneshot_disarm_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !perQ && !cmpWr) |=> !armedQ);
  assert_period_advance_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fire && perQ && !cmpWr) |=> (cmpQ == $past(cmpQ) + $past(periodQ)));
endmodule

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int             NCH       = 3,
  parameter int             REV       = 1,
  parameter logic [31:0]    PERIOD_FS = 32'd10000000,
  parameter logic [NCH-1:0] PCAP_MASK = NCH'(1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    irqOut
);
  localparam logic [DATA_W-1:0] CAPS_WORD =
    {16'h0, 2'b00, 1'b0, 5'(NCH-1), 8'(REV)};

  logic              runQ;
  logic [DATA_W-1:0] countQ;
  logic [NCH-1:0]    statusQ, setMask, clrMask;
  logic [DATA_W-1:0] cfgWords [NCH];
  logic [DATA_W-1:0] cmpVals  [NCH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      countQ <= '0;
    end else begin
      if (strobe.genWr) runQ <= wdata[0];
      if (strobe.cntWr)  countQ <= wdata;
      else if (runQ)     countQ <= countQ + 1'b1;
    end
  end

  assign clrMask = strobe.statWr ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrMask) | setMask;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    evt_timer_chan #(.PCAP(PCAP_MASK[i])) i_chan (
      .clk       (clk),
      .rstN      (rstN),
      .run       (runQ),
      .count     (countQ),
      .wdata     (wdata),
      .cfgWr     (strobe.cfgWr && strobe.chanIdx == IDX_W'(i)),
      .cmpWr     (strobe.cmpWr && strobe.chanIdx == IDX_W'(i)),
      .statusBit (statusQ[i]),
      .cfgWord   (cfgWords[i]),
      .cmpVal    (cmpVals[i]),
      .setStatus (setMask[i]),
      .irq       (irqOut[i])
    );
  end

  always_comb begin
    rdata = '0;
    unique case (strobe.rdSel)
      RD_CAPS:   rdata = CAPS_WORD;
      RD_PERIOD: rdata = PERIOD_FS;
      RD_GEN:    rdata = DATA_W'(runQ);
      RD_STAT:   rdata = DATA_W'(statusQ);
      RD_CNT:    rdata = countQ;
      RD_CFG, RD_CMP: begin
        for (int i = 0; i < NCH; i++) begin
          if (strobe.chanIdx == IDX_W'(i))
            rdata = (strobe.rdSel == RD_CFG) ? cfgWords[i] : cmpVals[i];
        end
      end
      default:   rdata = '0;
    endcase
  end

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !strobe.cntWr) |=> $stable(countQ));
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !strobe.cntWr) |=> (countQ == $past(countQ) + 32'd1));
  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (($past(statusQ) & ~$past(clrMask) & ~statusQ) == '0));
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int             NCH       = 3,
  parameter logic [31:0]    PERIOD_FS = 32'd10000000,
  parameter logic [NCH-1:0] PCAP_MASK = NCH'(1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           busSel,
  input  logic           busWr,
  input  logic [9:0]     busAddr,
  input  logic [31:0]    busWdata,
  output logic [31:0]    busRdata,
  output logic [NCH-1:0] irqOut
);
  evt_timer_pkg::busStrobe_t strobe;

  evt_timer_ctrl #(.NCH(NCH)) i_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  evt_timer_dp #(
    .NCH       (NCH),
    .REV       (1),
    .PERIOD_FS (PERIOD_FS),
    .PCAP_MASK (PCAP_MASK)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .irqOut (irqOut)
  );
endmodule

// File: tb/test_evt_timer.sv
module test_evt_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PFS = 32'd10000000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  irqOut;

  int unsigned cyc = 0;
  int unsigned expQ[$];
  int          checks = 0;
  int          errors = 0;
  int          pulses = 0;

  evt_timer #(.NCH(3), .PERIOD_FS(PFS), .PCAP_MASK(3'b001)) i_evt_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: every channel-0 pulse must match the next predicted cycle
  always @(negedge clk) begin
    if (rstN && irqOut[0]) begin
      pulses++;
      if (expQ.size() == 0) chk(1'b0, "R8 unexpected pulse", cyc, 0);
      else begin
        int unsigned e;
        e = expQ.pop_front();
        chk(cyc == e, "R3/R4 pulse cycle", cyc, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned cP;
    int p0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // reset state
    chk(irqOut == 3'b000, "R7 reset irq", 32'(irqOut), 0);
    rd(10'h0F0, v); chk(v == 0, "R2 reset counter", v, 0);
    rd(10'h010, v); chk(v == 0, "R2 reset run bit", v, 0);
    rd(10'h020, v); chk(v == 0, "R6 reset status", v, 0);

    // R1 capability words
    rd(10'h000, v); chk(v == 32'h0000_0201, "R1 caps", v, 32'h201);
    rd(10'h004, v); chk(v == PFS, "R1 period", v, PFS);

    // R2 gating and load
    tick(5);
    rd(10'h0F0, v); chk(v == 0, "R2 stopped hold", v, 0);
    wr(10'h0F0, 32'd100);
    rd(10'h0F0, v); chk(v == 100, "R2 load", v, 100);
    wr(10'h010, 1);
    tick(4);
    wr(10'h010, 0);
    rd(10'h0F0, v); chk(v == 105, "R2 count while running", v, 105);
    tick(3);
    rd(10'h0F0, v); chk(v == 105, "R2 hold after stop", v, 105);

    // R9 wrap
    wr(10'h0F0, 32'hFFFF_FFFE);
    wr(10'h010, 1);
    tick(2);
    rd(10'h0F0, v); chk(v == 0, "R9 wrap to zero", v, 0);
    wr(10'h010, 0);

    // R3 / R8 single-shot, pulse mode, channel 0 (R10 addresses)
    wr(10'h0F0, 0);
    wr(10'h100, 32'h04);
    wr(10'h108, 32'd20);
    p0 = pulses;
    wr(10'h010, 1);
    cP = cyc;
    expQ.push_back(cP + 21);
    tick(60);
    wr(10'h010, 0);
    chk(pulses - p0 == 1, "R3 exactly one fire", 32'(pulses - p0), 1);
    rd(10'h020, v); chk(v == 0, "R8 pulse mode sets no status", v, 0);

    // R4 repeating mode on channel 0
    wr(10'h0F0, 0);
    wr(10'h100, 32'h4C);
    rd(10'h100, v); chk(v == 32'h7C, "R4 config with arm-value", v, 32'h7C);
    wr(10'h108, 32'd10);
    rd(10'h100, v); chk(v == 32'h3C, "R4 arm-value self-clears", v, 32'h3C);
    wr(10'h108, 32'd7);
    rd(10'h108, v); chk(v == 10, "R4 interval write leaves first expiry", v, 10);
    p0 = pulses;
    wr(10'h010, 1);
    cP = cyc;
    expQ.push_back(cP + 11);
    expQ.push_back(cP + 18);
    expQ.push_back(cP + 25);
    tick(30);
    wr(10'h010, 0);
    chk(pulses - p0 == 3, "R4 three fires", 32'(pulses - p0), 3);
    rd(10'h108, v); chk(v == 31, "R4 comparator advanced", v, 31);
    wr(10'h100, 0);

    // R5 repeat bit ignored on channel 2 (no capability)
    wr(10'h140, 32'h0C);
    rd(10'h140, v); chk(v == 32'h24, "R5 repeat bit ignored", v, 32'h24);

    // R6 level mode, channel 1
    wr(10'h0F0, 0);
    wr(10'h120, 32'h06);
    wr(10'h128, 32'd4);
    wr(10'h010, 1);
    tick(10);
    wr(10'h010, 0);
    rd(10'h020, v); chk(v == 2, "R6 status set", v, 2);
    chk(irqOut[1] == 1'b1, "R6 level irq high", 32'(irqOut[1]), 1);
    wr(10'h020, 0);
    rd(10'h020, v); chk(v == 2, "R6 zero write no effect", v, 2);
    chk(irqOut[1] == 1'b1, "R6 irq stays after zero write", 32'(irqOut[1]), 1);
    wr(10'h020, 2);
    rd(10'h020, v); chk(v == 0, "R6 one clears", v, 0);
    chk(irqOut[1] == 1'b0, "R6 irq drops after clear", 32'(irqOut[1]), 0);

    // R7 enable off: status recorded, output quiet
    wr(10'h0F0, 0);
    wr(10'h120, 32'h02);
    wr(10'h128, 32'd3);
    wr(10'h010, 1);
    tick(8);
    wr(10'h010, 0);
    chk(irqOut[1] == 1'b0, "R7 output quiet when disabled", 32'(irqOut[1]), 0);
    rd(10'h020, v); chk(v == 2, "R7 status still recorded", v, 2);
    wr(10'h120, 32'h06);
    rd(10'h020, v);
    chk(irqOut[1] == 1'b1, "R7 output follows status once enabled", 32'(irqOut[1]), 1);
    wr(10'h020, 2);
    rd(10'h020, v);
    chk(irqOut[1] == 1'b0, "R7 output low after clear", 32'(irqOut[1]), 0);

    chk(expQ.size() == 0, "R3 all predicted pulses seen", 32'(expQ.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule